// File: doc/BRIEF.md
# Macro Instruction Sequencer Core

This block is a small in-order engine that runs short programs of 32-bit macro instructions kept in its own instruction memory. A host writes the program through a write port and then pulses `start`. The core loads register 1 from the head of a parameter stream, clears every other register, and steps through the program at two cycles per instruction. The program counter counts bytes. Instructions are fetched from a block-RAM style memory with a registered read. Eight 32-bit registers are held locally, and register 0 always reads as zero.

The core does not include the general ALU or the result dispatch. For the ALU-type classes it presents the instruction and both source operands on an issue port and takes back a combinational `alu_result`. The add-immediate and read classes are computed inside the core. The read class gets its value from an external state-register read port. Every executed non-branch instruction writes its destination register as its result operation directs and sends a registered record to the downstream dispatch unit.

Branches test source A against zero and are delayed by one slot, which a per-branch annul bit can suppress. An exit marker halts the core after one more instruction has run. Illegal encodings stop the core with a sticky error flag.

Top module: `macro_seq`

## Requirements
- R1: The add-immediate class (bits [2:0] = 1) produces source A (bits [13:11]) plus the sign-extended 18-bit immediate in bits [31:14]. The result is written to the destination register in bits [10:8].
- R2: Register 0 reads as zero, and a write that targets it has no effect.
- R3: A `start` pulse while idle asserts `param_take` in that cycle. It loads register 1 with `param_data` and clears the other registers and all sequencing state. `start` is ignored while busy.
- R4: The branch class (7) tests source A. Bit 4 = 0 branches on zero and bit 4 = 1 branches on non-zero. A taken branch goes to its own byte address plus 4 times the immediate, after first running the next instruction as a delay slot. A branch that is not taken falls through.
- R5: A taken branch with bit 5 set skips the delay slot and redirects at once.
- R6: Bit 7 marks an exit. The next instruction runs as a delay slot, after which the core halts, drops `busy` and pulses `done` for exactly one cycle.
- R7: An exit marker on an instruction that is itself in a delay slot is ignored.
- R8: The read class (5) drives `rd_addr` with source A plus the immediate and uses `rd_data` as its result.
- R9: Class 6, or a branch inside a delay slot, sets `error`, which stays set until the next start. It halts the core without a `done` pulse.
- R10: The result operation in bits [6:4] controls parameter use. Values 0, 3 and 5 write the next stream parameter to the destination, and value 6 fetches one for sending. Each fetch pulses `param_take` once. Every executed non-branch instruction gives one `res_valid` record carrying the result and the fetched parameter.
- R11: Classes 0, 2, 3 and 4 assert `issue_valid` with the instruction and both source operands, and take `alu_result` as their result.
- R12: After reset, `busy`, `done`, `error` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin running the loaded program from address 0 |
| prog_we | input | 1 | Instruction memory write enable |
| prog_addr | input | IAW | Instruction memory word address |
| prog_wdata | input | 32 | Instruction word to write |
| param_data | input | 32 | Head of the parameter stream |
| param_take | output | 1 | Consumes the stream head this cycle |
| rd_addr | output | 32 | External state-register read address |
| rd_data | input | 32 | External state-register read value (same cycle) |
| issue_valid | output | 1 | An ALU-type instruction is issued this cycle |
| issue_instr | output | 32 | Instruction word for the external ALU |
| issue_a | output | 32 | Source A operand value |
| issue_b | output | 32 | Source B operand value |
| alu_result | input | 32 | Combinational result from the external ALU |
| res_valid | output | 1 | A result record is valid |
| res_op | output | 3 | Result operation of the record |
| res_value | output | 32 | Instruction result |
| res_param | output | 32 | Parameter fetched by the instruction |
| busy | output | 1 | A program is running |
| done | output | 1 | One-cycle pulse on a normal halt |
| error | output | 1 | Sticky illegal-encoding flag |

## Verification
The sequencing logic is exercised by a set of short programs. Each is compared on its record count and final result. The count tells apart whether a delay slot ran, was annulled, or was followed past an exit. A backward-looping branch confirms sign handling of the target offset. A program that reads a register left dirty by the previous run checks the clear at start. A mixed program covers reads, parameter fetches and the zero register, and its individual records are inspected. The two illegal cases are told apart from a normal halt by error set and done absent.

// File: rtl/macro_pkg.sv
package macro_pkg;

  typedef enum logic [2:0] {
    OP_ALU    = 3'd0,
    OP_ADDI   = 3'd1,
    OP_BFINS  = 3'd2,
    OP_BFSHI  = 3'd3,
    OP_BFSHR  = 3'd4,
    OP_READ   = 3'd5,
    OP_BAD    = 3'd6,
    OP_BRANCH = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_EXEC  = 2'd2
  } seq_state_e;

  typedef struct packed {
    op_class_e   cls;
    logic [2:0]  rop;
    logic        bnz;
    logic        annul;
    logic        fin;
    logic [2:0]  dst;
    logic [2:0]  sa;
    logic [2:0]  sb;
    logic [31:0] imm;
  } dec_t;

  function automatic dec_t decode_word(input logic [31:0] w);
    dec_t d;
    d.cls   = op_class_e'(w[2:0]);
    d.rop   = w[6:4];
    d.bnz   = w[4];
    d.annul = w[5];
    d.fin   = w[7];
    d.dst   = w[10:8];
    d.sa    = w[13:11];
    d.sb    = w[16:14];
    d.imm   = {{14{w[31]}}, w[31:14]};
    return d;
  endfunction

  // result operations that write the fetched parameter into the destination
  function automatic logic rop_writes_param(input logic [2:0] r);
    return (r == 3'd0) || (r == 3'd3) || (r == 3'd5);
  endfunction

  function automatic logic rop_fetches(input logic [2:0] r);
    return rop_writes_param(r) || (r == 3'd6);
  endfunction

  function automatic logic is_alu_class(input op_class_e c);
    return (c == OP_ALU) || (c == OP_BFINS) || (c == OP_BFSHI) || (c == OP_BFSHR);
  endfunction

endpackage

// File: rtl/macro_imem.sv
module macro_imem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/macro_regfile.sv
module macro_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int RIW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [DW-1:0]  r1_init,
  input  logic           we,
  input  logic [RIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RIW-1:0] ra,
  input  logic [RIW-1:0] rb,
  output logic [DW-1:0]  qa,
  output logic [DW-1:0]  qb
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    regs[0] <= '0;
    for (int i = 1; i < NREG; i++) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (clr) begin
        regs[i] <= (i == 1) ? r1_init : '0;
      end else if (we && (waddr == RIW'(i))) begin
        regs[i] <= wdata;
      end
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];

endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import macro_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int NREG       = 8,
  localparam int DW        = 32,
  localparam int IAW       = $clog2(IMEM_DEPTH),
  localparam int PCW       = IAW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           prog_we,
  input  logic [IAW-1:0] prog_addr,
  input  logic [DW-1:0]  prog_wdata,
  input  logic [DW-1:0]  param_data,
  output logic           param_take,
  output logic [DW-1:0]  rd_addr,
  input  logic [DW-1:0]  rd_data,
  output logic           issue_valid,
  output logic [DW-1:0]  issue_instr,
  output logic [DW-1:0]  issue_a,
  output logic [DW-1:0]  issue_b,
  input  logic [DW-1:0]  alu_result,
  output logic           res_valid,
  output logic [2:0]     res_op,
  output logic [DW-1:0]  res_value,
  output logic [DW-1:0]  res_param,
  output logic           busy,
  output logic           done,
  output logic           error
);

  seq_state_e    st;
  logic [PCW-1:0] pc, dtgt;
  logic          in_slot, redir_pend, exit_pend;
  logic [DW-1:0] instr, a_val, b_val, value, wr_data;
  dec_t          d;
  logic          exec, is_br, bad, taken, exit_now, wr_en, fetch, launch;
  logic [PCW-1:0] br_tgt, pc_seq;

  macro_imem #(.DW(DW), .DEPTH(IMEM_DEPTH), .AW(IAW)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_wdata),
    .raddr (pc[PCW-1:2]),
    .rdata (instr)
  );

  macro_regfile #(.DW(DW), .NREG(NREG), .RIW(3)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .clr     (launch),
    .r1_init (param_data),
    .we      (wr_en),
    .waddr   (d.dst),
    .wdata   (wr_data),
    .ra      (d.sa),
    .rb      (d.sb),
    .qa      (a_val),
    .qb      (b_val)
  );

  always_comb begin
    d        = decode_word(instr);
    exec     = (st == S_EXEC);
    launch   = (st == S_IDLE) && start;
    is_br    = (d.cls == OP_BRANCH);
    bad      = (d.cls == OP_BAD) || (is_br && in_slot);
    taken    = is_br && (d.bnz ? (a_val != '0) : (a_val == '0));
    br_tgt   = pc + {d.imm[PCW-3:0], 2'b00};
    pc_seq   = pc + PCW'(4);
    exit_now = d.fin && !in_slot && !(taken && !d.annul);
    rd_addr  = a_val + d.imm;
    case (d.cls)
      OP_ADDI: value = a_val + d.imm;
      OP_READ: value = rd_data;
      default: value = alu_result;
    endcase
    wr_en      = exec && !is_br && !bad;
    fetch      = wr_en && rop_fetches(d.rop);
    wr_data    = rop_writes_param(d.rop) ? param_data : value;
    param_take = launch || fetch;
    issue_valid = exec && !bad && is_alu_class(d.cls);
    issue_instr = instr;
    issue_a     = a_val;
    issue_b     = b_val;
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      pc         <= '0;
      dtgt       <= '0;
      in_slot    <= 1'b0;
      redir_pend <= 1'b0;
      exit_pend  <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      res_valid  <= 1'b0;
      res_op     <= '0;
      res_value  <= '0;
      res_param  <= '0;
    end else begin
      done      <= 1'b0;
      res_valid <= wr_en;
      if (wr_en) begin
        res_op    <= d.rop;
        res_value <= value;
        res_param <= fetch ? param_data : '0;
      end
      case (st)
        S_IDLE: begin
          if (start) begin
            st         <= S_FETCH;
            pc         <= '0;
            in_slot    <= 1'b0;
            redir_pend <= 1'b0;
            exit_pend  <= 1'b0;
            error      <= 1'b0;
          end
        end
        S_FETCH: st <= S_EXEC;
        default: begin
          if (bad) begin
            error <= 1'b1;
            st    <= S_IDLE;
          end else if (in_slot) begin
            in_slot <= 1'b0;
            if (exit_pend) begin
              exit_pend <= 1'b0;
              done      <= 1'b1;
              st        <= S_IDLE;
            end else begin
              st         <= S_FETCH;
              pc         <= redir_pend ? dtgt : pc_seq;
              redir_pend <= 1'b0;
            end
          end else begin
            st <= S_FETCH;
            pc <= (taken && d.annul) ? br_tgt : pc_seq;
            if (taken && !d.annul) begin
              in_slot    <= 1'b1;
              redir_pend <= 1'b1;
              dtgt       <= br_tgt;
            end
            if (exit_now) begin
              in_slot   <= 1'b1;
              exit_pend <= 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/macro_seq_chk.sv
module macro_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic error,
  input logic res_valid,
  input logic issue_valid,
  input logic param_take
);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_err_no_done_R9: assert property (@(posedge clk) disable iff (rst)
    error |-> !done);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

  assert_res_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(busy));

  assert_issue_busy_R11: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> busy);

  assert_start_take_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> param_take);

  assert_start_runs_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

endmodule

bind macro_seq macro_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .res_valid   (res_valid),
  .issue_valid (issue_valid),
  .param_take  (param_take)
);

// File: tb/macro_seq_tb.sv
module macro_seq_tb;

  localparam int NT = 11;
  localparam logic [31:0] EX = 32'h80;

  function automatic logic [31:0] f_ai(input int rop, input int d, input int a, input int imm);
    return {imm[17:0], a[2:0], d[2:0], 1'b0, rop[2:0], 1'b0, 3'd1};
  endfunction
  function automatic logic [31:0] f_rd(input int rop, input int d, input int a, input int imm);
    return {imm[17:0], a[2:0], d[2:0], 1'b0, rop[2:0], 1'b0, 3'd5};
  endfunction
  function automatic logic [31:0] f_alu(input int rop, input int d, input int a, input int b);
    return {15'd0, b[2:0], a[2:0], d[2:0], 1'b0, rop[2:0], 1'b0, 3'd0};
  endfunction
  function automatic logic [31:0] f_br(input int nz, input int an, input int a, input int imm);
    return {imm[17:0], a[2:0], 3'd0, 2'b00, an[0], nz[0], 1'b0, 3'd7};
  endfunction

  // program table, eight words each, and expected record count / last value / error
  localparam logic [31:0] PROG [NT][8] = '{
    // 0 R1 add-immediate with negative immediate, exit
    '{f_ai(1,2,1,5), f_ai(1,3,2,-1)|EX, f_ai(1,4,3,16), f_ai(1,5,0,7), 0, 0, 0, 0},
    // 1 R4 taken branch on zero with delay slot
    '{f_br(0,0,0,3), f_ai(1,2,0,1), f_ai(1,3,0,2), f_ai(1,4,2,32)|EX, f_ai(1,5,0,9), 0, 0, 0},
    // 2 R5 annulled taken branch on non-zero
    '{f_br(1,1,1,2), f_ai(1,2,0,119), f_ai(1,3,1,0)|EX, f_ai(1,4,0,3), 0, 0, 0, 0},
    // 3 R4 branch not taken
    '{f_br(1,0,0,5), f_ai(1,2,0,4), f_ai(1,3,2,4)|EX, f_ai(1,4,3,1), 0, 0, 0, 0},
    // 4 R8 R2 R10 read, zero register, parameter fetch
    '{f_ai(1,0,1,5), f_rd(1,2,0,64), f_ai(0,3,0,0), f_ai(1,5,0,0), f_ai(1,6,3,0)|EX, f_ai(1,7,2,1), 0, 0},
    // 5 R11 external ALU path
    '{f_alu(1,2,1,1), f_ai(1,3,2,1)|EX, f_alu(1,4,2,3), 0, 0, 0, 0, 0},
    // 6 R5 backward loop
    '{f_ai(1,2,0,3), f_ai(1,2,2,-1), f_br(1,1,2,-1), f_ai(1,3,0,85)|EX, f_ai(1,4,0,102), 0, 0, 0},
    // 7 R7 exit inside delay slot ignored
    '{f_br(0,0,0,3), f_ai(1,2,0,1)|EX, f_ai(1,5,0,5), f_ai(1,3,0,3)|EX, f_ai(1,4,0,4), 0, 0, 0},
    // 8 R3 registers cleared at start (r2 left at 1 by test 7)
    '{f_ai(1,3,2,0)|EX, f_ai(1,4,3,7), 0, 0, 0, 0, 0, 0},
    // 9 R9 class 6
    '{f_ai(1,2,0,1), 32'h6, f_ai(1,3,0,2), 0, 0, 0, 0, 0},
    // 10 R9 branch in delay slot
    '{f_br(0,0,0,2), f_br(0,0,0,1), f_ai(1,3,0,2), 0, 0, 0, 0, 0}
  };
  localparam int          EXP_CNT  [NT] = '{3, 3, 2, 3, 6, 3, 6, 3, 2, 1, 0};
  localparam logic [31:0] EXP_LAST [NT] = '{32'h114, 32'h9, 32'h3, 32'h9, 32'hA5A50041,
                                           32'h401, 32'h66, 32'h4, 32'h7, 32'h1, 32'h0};
  localparam bit          EXP_ERR  [NT] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam string       TAG      [NT] = '{"R1", "R4", "R5", "R4", "R8", "R11", "R5",
                                           "R7", "R3", "R9", "R9"};

  logic        clk = 0, rst = 1, start = 0, prog_we = 0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_wdata = '0;
  logic [31:0] param_data, rd_addr, rd_data, issue_instr, issue_a, issue_b, alu_result;
  logic [31:0] res_value, res_param;
  logic [2:0]  res_op;
  logic        param_take, issue_valid, res_valid, busy, done, error;

  int checks = 0, fails = 0;
  int take_cnt = 0, take_base = 0;
  int ev_cnt = 0;
  logic [31:0] log_val [256];
  logic [31:0] log_par [256];

  always #2.5 clk = ~clk;

  assign param_data = 32'h100 + 32'(take_cnt - take_base);
  assign rd_data    = rd_addr ^ 32'hA5A50000;
  assign alu_result = issue_a + issue_b;

  always @(posedge clk) if (param_take) take_cnt <= take_cnt + 1;

  always @(negedge clk) begin
    if (res_valid) begin
      log_val[ev_cnt[7:0]] = res_value;
      log_par[ev_cnt[7:0]] = res_param;
      ev_cnt = ev_cnt + 1;
    end
  end

  macro_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .param_data(param_data), .param_take(param_take),
    .rd_addr(rd_addr), .rd_data(rd_data), .issue_valid(issue_valid),
    .issue_instr(issue_instr), .issue_a(issue_a), .issue_b(issue_b),
    .alu_result(alu_result), .res_valid(res_valid), .res_op(res_op),
    .res_value(res_value), .res_param(res_param), .busy(busy), .done(done),
    .error(error)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  int ev_base;
  bit saw_done, saw_err;

  task automatic run_prog(input int t);
    int n;
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      prog_we = 1; prog_addr = 6'(w); prog_wdata = PROG[t][w];
    end
    @(negedge clk);
    prog_we = 0;
    take_base = take_cnt;
    ev_base = ev_cnt;
    start = 1;
    @(negedge clk);
    start = 0;
    check(TAG[t], "busy after start", {31'd0, busy}, 32'd1);
    n = 0;
    saw_done = 0; saw_err = 0;
    while (!done && !error && n < 500) begin
      @(negedge clk);
      n++;
    end
    saw_done = done; saw_err = error;
    @(negedge clk);
    if (saw_done) check("R6", "done one cycle", {31'd0, done}, 32'd0);
    check(TAG[t], "error flag", {31'd0, saw_err}, {31'd0, EXP_ERR[t]});
    check(TAG[t], "done flag", {31'd0, saw_done}, {31'd0, !EXP_ERR[t]});
    check(TAG[t], "record count", 32'(ev_cnt - ev_base), 32'(EXP_CNT[t]));
    check(TAG[t], "last result",
          (ev_cnt > ev_base) ? log_val[8'(ev_cnt - 1)] : 32'h0, EXP_LAST[t]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check("R12", "busy", {31'd0, busy}, 32'd0);
    check("R12", "done", {31'd0, done}, 32'd0);
    check("R12", "error", {31'd0, error}, 32'd0);
    check("R12", "res_valid", {31'd0, res_valid}, 32'd0);

    for (int t = 0; t < NT; t++) begin
      run_prog(t);
      if (t == 4) begin
        // R2: r0 write discarded, later read of r0 gives zero
        check("R2", "zero register read", log_val[8'(ev_base + 3)], 32'h0);
        // R8: read address 0 + 64 returns the mapped value
        check("R8", "read result", log_val[8'(ev_base + 1)], 32'hA5A50040);
        // R10: fetch gets second stream word
        check("R10", "fetched param", log_par[8'(ev_base + 2)], 32'h101);
        check("R10", "param written", log_val[8'(ev_base + 4)], 32'h101);
        check("R10", "take count", 32'(take_cnt - take_base), 32'd2);
      end
      if (t == 9) begin
        // R9: error stays set while idle
        repeat (3) @(negedge clk);
        check("R9", "error sticky", {31'd0, error}, 32'd1);
        check("R9", "halted", {31'd0, busy}, 32'd0);
      end
    end

    // R3: start ignored while busy (second start during a run)
    take_base = take_cnt;
    ev_base = ev_cnt;
    @(negedge clk); start = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    check("R3", "start while busy ignored take count", 32'(take_cnt - take_base), 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule